// File: doc/BRIEF.md
# System Integrity Control and Status Register

This block is a single byte-wide control/status register that reports the health of a small controller's supply and clock. It shows whether the clock multiplier has locked and whether the supply is currently below the voltage-monitor threshold. It keeps a sticky record that the last reset came from the low-voltage detector. It also holds the enable for the voltage-monitor interrupt. Hardware status inputs are registered before they reach the read path. The bus presents the register contents on `bus_rdata` at all times. A write strobe updates the writable bits.

The block accepts four reset causes. Power-on, external, watchdog and low-voltage events all return the control and status bits to zero. Only power-on clears the low-voltage flag, and a low-voltage event sets it. This lets software read the cause of the last reset after an external or watchdog reset. The voltage-monitor interrupt is latched on a rising edge of the monitor flag while the enable is set. The latch is cleared by the CPU's acknowledge strobe when it enters the handler.

Top module: `sysint_csr`

## Requirements
- R1: Bits 7..4 of `bus_rdata` always read 0, and writing ones to them changes nothing.
- R2: Bit 3 shows `pll_lock_i` as sampled at the previous clock edge, and bus writes do not affect it.
- R3: Bit 2 (low-voltage reset flag) becomes 1 after a clock edge with `lvr_event` high. A write with data bit 2 = 0 clears it. A write with data bit 2 = 1 leaves it unchanged.
- R4: `rst_ext` and `rst_wdg` leave bit 2 unchanged. `rst_por` without `lvr_event` clears bit 2.
- R5: Bit 1 shows `vmon_below_i` as sampled at the previous clock edge (1 = supply below threshold), and bus writes do not affect it.
- R6: Bit 0 is the interrupt enable. It is loaded from data bit 0 on every write and reads back what was written.
- R7: A pending interrupt is latched when bit 1 goes from 0 to 1 while bit 0 is 1. A rise while bit 0 is 0 latches nothing. `irq_o` equals pending AND bit 0, so clearing the enable masks the output but keeps the pending state.
- R8: An edge with `irq_ack` high clears the pending state. If a new rise of bit 1 happens at the same edge, the rise wins and the interrupt stays pending.
- R9: If `lvr_event` and a write with data bit 2 = 0 come at the same edge, bit 2 ends up 1.
- R10: Any of `rst_por`, `rst_ext`, `rst_wdg` or `lvr_event` clears bits 3, 1 and 0 and the pending state at the next edge, so `bus_rdata & 8'hFB` = 0 and `irq_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_ext | input | 1 | External pin reset, synchronous, active high |
| rst_wdg | input | 1 | Watchdog reset, synchronous, active high |
| lvr_event | input | 1 | Low-voltage detector reset event |
| pll_lock_i | input | 1 | Clock multiplier lock status |
| vmon_below_i | input | 1 | Supply below voltage-monitor threshold |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register contents |
| irq_ack | input | 1 | CPU entered the voltage-monitor handler |
| irq_o | output | 1 | Voltage-monitor interrupt request |

## Verification
Every result appears one clock edge after its cause, with the default of one status stage. This covers a sampled status input, a write, a reset cause, a new pending interrupt and an acknowledge. The bench drives inputs on the falling edge and compares `bus_rdata` and `irq_o` at the next falling edge, which is half a period after the rising edge that made them. Corner cases are checked at that same single-edge point. These are a rise and an acknowledge together, a low-voltage event together with a clearing write, and each reset cause in turn.

// File: rtl/sysint_pkg.sv
package sysint_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned BIT_PLL  = 3;
    localparam int unsigned BIT_LVR  = 2;
    localparam int unsigned BIT_VMON = 1;
    localparam int unsigned BIT_IEN  = 0;

    // live hardware status fields, sampled as a group
    typedef struct packed {
        logic pll_lock;
        logic vmon_below;
    } hw_status_t;

    localparam int unsigned HW_W = $bits(hw_status_t);

    typedef struct packed {
        logic pll_lock;
        logic lvr_flag;
        logic vmon_below;
        logic irq_en;
    } csr_fields_t;

    typedef struct packed {
        logic any_rst;
        logic lvr_set;
        logic lvr_clr;
    } rst_ctl_t;

    function automatic logic [REG_W-1:0] pack_csr(input csr_fields_t f);
        logic [REG_W-1:0] v;
        v           = '0;
        v[BIT_PLL]  = f.pll_lock;
        v[BIT_LVR]  = f.lvr_flag;
        v[BIT_VMON] = f.vmon_below;
        v[BIT_IEN]  = f.irq_en;
        return v;
    endfunction

endpackage

// File: rtl/sysint_rst_ctrl.sv
module sysint_rst_ctrl
    import sysint_pkg::*;
(
    input  logic     rst_por,
    input  logic     rst_ext,
    input  logic     rst_wdg,
    input  logic     lvr_event,
    output rst_ctl_t ctl
);
    always_comb begin
        ctl.any_rst = rst_por | rst_ext | rst_wdg | lvr_event;
        ctl.lvr_set = lvr_event;
        ctl.lvr_clr = rst_por & ~lvr_event;
    end
endmodule

// File: rtl/sysint_status_pipe.sv
module sysint_status_pipe #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_next
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] st [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[i] <= '0;
                else     st[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[i] <= '0;
                else     st[i] <= st[i-1];
            end
        end
    end

    if (STAGES == 1) begin : g_nx1
        assign q_next = din;
    end else begin : g_nxn
        assign q_next = st[LAST-1];
    end

    assign q = st[LAST];
endmodule

// File: rtl/sysint_lvr_flag.sv
module sysint_lvr_flag (
    input  logic clk,
    input  logic set_hw,
    input  logic clr_por,
    input  logic sw_wr,
    input  logic sw_bit,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (set_hw)                  flag <= 1'b1;
        else if (clr_por)            flag <= 1'b0;
        else if (sw_wr && !sw_bit)   flag <= 1'b0;
    end
endmodule

// File: rtl/sysint_irq_ctrl.sv
module sysint_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic flag_q,
    input  logic flag_next,
    input  logic ien,
    input  logic ack,
    output logic irq
);
    logic pend_q;
    logic rise;

    assign rise = flag_next & ~flag_q & ien;

    always_ff @(posedge clk) begin
        if (rst)       pend_q <= 1'b0;
        else if (rise) pend_q <= 1'b1;
        else if (ack)  pend_q <= 1'b0;
    end

    assign irq = pend_q & ien;
endmodule

// File: rtl/sysint_csr.sv
module sysint_csr
    import sysint_pkg::*;
#(
    parameter int unsigned STATUS_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_por,
    input  logic             rst_ext,
    input  logic             rst_wdg,
    input  logic             lvr_event,
    input  logic             pll_lock_i,
    input  logic             vmon_below_i,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             irq_ack,
    output logic             irq_o
);
    rst_ctl_t    rctl;
    hw_status_t  hw_in, hw_q, hw_nx;
    csr_fields_t fields;
    logic        lvr_q;
    logic        ien_q;
    logic        wr_ok;

    sysint_rst_ctrl u_rst (
        .rst_por   (rst_por),
        .rst_ext   (rst_ext),
        .rst_wdg   (rst_wdg),
        .lvr_event (lvr_event),
        .ctl       (rctl)
    );

    assign hw_in = '{pll_lock: pll_lock_i, vmon_below: vmon_below_i};

    sysint_status_pipe #(
        .WIDTH  (HW_W),
        .STAGES (STATUS_STAGES)
    ) u_pipe (
        .clk    (clk),
        .rst    (rctl.any_rst),
        .din    (hw_in),
        .q      (hw_q),
        .q_next (hw_nx)
    );

    assign wr_ok = bus_we & ~rctl.any_rst;

    sysint_lvr_flag u_lvr (
        .clk     (clk),
        .set_hw  (rctl.lvr_set),
        .clr_por (rctl.lvr_clr),
        .sw_wr   (wr_ok),
        .sw_bit  (bus_wdata[BIT_LVR]),
        .flag    (lvr_q)
    );

    always_ff @(posedge clk) begin
        if (rctl.any_rst) ien_q <= 1'b0;
        else if (wr_ok)   ien_q <= bus_wdata[BIT_IEN];
    end

    sysint_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rctl.any_rst),
        .flag_q    (hw_q.vmon_below),
        .flag_next (hw_nx.vmon_below),
        .ien       (ien_q),
        .ack       (irq_ack),
        .irq       (irq_o)
    );

    always_comb begin
        fields.pll_lock   = hw_q.pll_lock;
        fields.lvr_flag   = lvr_q;
        fields.vmon_below = hw_q.vmon_below;
        fields.irq_en     = ien_q;
    end

    assign bus_rdata = pack_csr(fields);
endmodule

// File: rtl/sysint_csr_chk.sv
module sysint_csr_chk (
    input logic       clk,
    input logic       rst_por,
    input logic       rst_ext,
    input logic       rst_wdg,
    input logic       lvr_event,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       irq_ack,
    input logic       irq_o
);
    logic armed = 1'b0;
    always_ff @(posedge clk) if (rst_por) armed <= 1'b1;

    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!armed)
        bus_rdata[7:4] == 4'h0);

    p_lvr_set_r3: assert property (@(posedge clk) disable iff (!armed)
        lvr_event |=> bus_rdata[2]);

    p_lvr_keep_r4: assert property (@(posedge clk) disable iff (!armed)
        ((rst_ext || rst_wdg) && !rst_por && !bus_we && bus_rdata[2]) |=> bus_rdata[2]);

    p_por_clear_r4: assert property (@(posedge clk) disable iff (!armed)
        (rst_por && !lvr_event) |=> !bus_rdata[2]);

    p_irq_mask_r7: assert property (@(posedge clk) disable iff (!armed)
        irq_o |-> bus_rdata[0]);

    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!armed)
        (irq_ack && bus_rdata[1]) |=> !irq_o);

    p_lvr_prio_r9: assert property (@(posedge clk) disable iff (!armed)
        (lvr_event && bus_we && !bus_wdata[2]) |=> bus_rdata[2]);

    p_rst_clear_r10: assert property (@(posedge clk) disable iff (!armed)
        (rst_por || rst_ext || rst_wdg || lvr_event) |=> ((bus_rdata & 8'hFB) == 8'h00 && !irq_o));
endmodule

bind sysint_csr sysint_csr_chk u_chk (
    .clk       (clk),
    .rst_por   (rst_por),
    .rst_ext   (rst_ext),
    .rst_wdg   (rst_wdg),
    .lvr_event (lvr_event),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_ack   (irq_ack),
    .irq_o     (irq_o)
);

// File: tb/sysint_csr_tb.sv
module sysint_csr_tb;

    typedef struct packed {
        logic       pll;
        logic       vmon;
        logic       we;
        logic [7:0] wdata;
        logic       ack;
        logic [7:0] exp_rd;
        logic       exp_irq;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h08, 1'b0},  // R2 lock sampled
        '{1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h09, 1'b0},  // R1 R3 R6 write all ones
        '{1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h0B, 1'b1},  // R5 R7 rise with enable
        '{1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'h0B, 1'b0},  // R8 ack clears
        '{1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h09, 1'b0},  // R5 flag falls
        '{1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h0B, 1'b1},  // R7 second rise
        '{1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 8'h0A, 1'b0},  // R7 masked by enable=0
        '{1'b1, 1'b1, 1'b1, 8'h01, 1'b0, 8'h0B, 1'b1},  // R7 pending kept, unmasked
        '{1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h09, 1'b0},  // R8 ack
        '{1'b1, 1'b0, 1'b1, 8'hF0, 1'b0, 8'h08, 1'b0},  // R1 R6 disable
        '{1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h0A, 1'b0},  // R7 rise while disabled
        '{1'b1, 1'b1, 1'b1, 8'h0B, 1'b0, 8'h0B, 1'b0},  // R2 R5 R7 no rise when enabled later
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0},  // R2 R5 status low
        '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h03, 1'b1}   // R8 rise beats ack
    };

    logic       clk = 1'b0;
    logic       rst_por = 1'b0, rst_ext = 1'b0, rst_wdg = 1'b0, lvr_event = 1'b0;
    logic       pll_lock_i = 1'b0, vmon_below_i = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sysint_csr u_dut (
        .clk          (clk),
        .rst_por      (rst_por),
        .rst_ext      (rst_ext),
        .rst_wdg      (rst_wdg),
        .lvr_event    (lvr_event),
        .pll_lock_i   (pll_lock_i),
        .vmon_below_i (vmon_below_i),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_ack      (irq_ack),
        .irq_o        (irq_o)
    );

    task automatic check(input string req, input logic [7:0] exp_rd, input logic exp_irq);
        n_cmp++;
        if (bus_rdata !== exp_rd || irq_o !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     req, bus_rdata, irq_o, exp_rd, exp_irq);
        end
    endtask

    // one edge: inputs already set at a falling edge, result read at the next falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        {rst_por, rst_ext, rst_wdg, lvr_event, bus_we, irq_ack} = '0;
        bus_wdata = 8'h00;
    endtask

    initial begin
        #(20 * 5000);
        n_bad++;
        $display("FAIL watchdog: rdata=%h irq=%b expected completion", bus_rdata, irq_o);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_por = 1'b1; pll_lock_i = 1'b1; vmon_below_i = 1'b1;
        step();
        step();
        check("R10 R4 reset state", 8'h00, 1'b0);
        idle();
        pll_lock_i = 1'b0; vmon_below_i = 1'b0;
        step();
        check("R10 idle after reset", 8'h00, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            pll_lock_i   = VEC[i].pll;
            vmon_below_i = VEC[i].vmon;
            bus_we       = VEC[i].we;
            bus_wdata    = VEC[i].wdata;
            irq_ack      = VEC[i].ack;
            step();
            check($sformatf("vector %0d", i), VEC[i].exp_rd, VEC[i].exp_irq);
        end
        idle();

        // low-voltage event with status high: R3 R10
        pll_lock_i = 1'b1; vmon_below_i = 1'b0;
        bus_we = 1'b1; bus_wdata = 8'h01; step(); idle();
        lvr_event = 1'b1; step(); idle();
        check("R3 R10 low-voltage event", 8'h04, 1'b0);
        step();
        check("R2 R3 status back after event", 8'h0C, 1'b0);

        rst_ext = 1'b1; step(); idle();
        check("R4 external reset keeps flag", 8'h04, 1'b0);
        rst_wdg = 1'b1; step(); idle();
        check("R4 watchdog reset keeps flag", 8'h04, 1'b0);
        step();

        bus_we = 1'b1; bus_wdata = 8'hFF; step(); idle();
        check("R3 writing one leaves flag", 8'h0D, 1'b0);
        bus_we = 1'b1; bus_wdata = 8'hFB; step(); idle();
        check("R3 writing zero clears flag", 8'h09, 1'b0);

        lvr_event = 1'b1; bus_we = 1'b1; bus_wdata = 8'h00; step(); idle();
        check("R9 event beats clearing write", 8'h04, 1'b0);

        rst_por = 1'b1; step(); idle();
        check("R4 power-on clears flag", 8'h00, 1'b0);

        // pending cleared by reset: R10
        step();
        bus_we = 1'b1; bus_wdata = 8'h01; step(); idle();
        vmon_below_i = 1'b1; step();
        check("R7 pending before reset", 8'h0B, 1'b1);
        rst_wdg = 1'b1; step(); idle();
        check("R10 watchdog clears enable and pending", 8'h04 & 8'h00, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule